// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher with Wildcard Fields

This block decides, once per clock update, whether the current hours, minutes and seconds equal a programmed alarm time. Each of the three alarm bytes is compared with its time byte. An alarm byte whose two most significant bits are both 1 is a wildcard and matches any time value. Wildcards let one alarm setting fire once a day, once an hour, once a minute or once a second.

The comparison runs only on the cycle where the timekeeping logic pulses its update-done strobe. A match on that cycle sets a sticky alarm flag. The flag stays set until a clear strobe arrives; the clear strobe is taken from a read of the status register. The interrupt output is the flag gated by the alarm-interrupt enable bit. Time counting, register decoding and number formatting are handled elsewhere.

Top module: `rtc_alarm_match`

## Requirements
- R1: While `rst` is high, the flag clears on the next clock edge. Once the edge has passed, `alarm_flag` and `alarm_irq` are both 0.
- R2: `upd_done` may be high on a clock edge while every field matches. The flag is then 1 from that edge onward.
- R3: The flag is never set on an edge where `upd_done` is low, even if every field matches.
- R4: An alarm byte with bits [7:6] = 2'b11 (values 0xC0 to 0xFF) is a wildcard and matches any time value. Any other alarm byte matches only when all 8 bits equal the time byte. For example, 0xBF does not match 0x3F.
- R5: An update where any non-wildcard field differs leaves a clear flag clear.
- R6: The flag is sticky. It holds through later updates that do not match. It clears on the edge after `flag_clr` is sampled high, provided there is no simultaneous match.
- R7: If `flag_clr` is high on the same edge as an update that matches, the flag stays 1.
- R8: `alarm_irq` equals `alarm_flag` AND `alarm_en` with no added delay. If `alarm_en` goes high while the flag is set, the interrupt asserts in that same cycle. `alarm_en` never changes the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_done | input | 1 | One-cycle pulse at the end of each time update |
| time_hr | input | 8 | Current hours byte |
| time_min | input | 8 | Current minutes byte |
| time_sec | input | 8 | Current seconds byte |
| alm_hr | input | 8 | Hours alarm byte (wildcard if [7:6]=11) |
| alm_min | input | 8 | Minutes alarm byte (wildcard if [7:6]=11) |
| alm_sec | input | 8 | Seconds alarm byte (wildcard if [7:6]=11) |
| alarm_en | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Clear strobe from a status read |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request contribution |

## Verification
A field comparator that decodes the wildcard wrongly changes `alarm_flag` one clock edge after the next update strobe. The flag then rises where it should not, or stays low where it should rise. A flag register that has lost its sticky hold, or that gives priority to the clear, shows as a wrong level one edge after a clear or an update. The bench samples at the negative edge, so every such error appears within one cycle of the stimulus that exposes it. A fault in the enable gating appears on `alarm_irq` in the same cycle the enable or the flag changes.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_FIELDS = 3;
  localparam int unsigned WILD_BITS  = 2;

  typedef logic [FIELD_W-1:0] field_t;

  // A byte is a wildcard when every one of its top WILD_BITS bits is set.
  function automatic logic is_wild(input field_t b);
    return &b[FIELD_W-1 -: WILD_BITS];
  endfunction
endpackage

// File: rtl/rtc_alarm_field_cmp.sv
module rtc_alarm_field_cmp
  import rtc_alarm_pkg::*;
(
  input  field_t cur_val,
  input  field_t alm_val,
  output logic   hit
);
  always_comb begin
    hit = is_wild(alm_val) || (cur_val == alm_val);
  end
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;   // set has priority over clear
    else if (clr_req) flag_q <= 1'b0;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_done,
  input  logic [7:0] time_hr,
  input  logic [7:0] time_min,
  input  logic [7:0] time_sec,
  input  logic [7:0] alm_hr,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_sec,
  input  logic       alarm_en,
  input  logic       flag_clr,
  output logic       alarm_flag,
  output logic       alarm_irq
);
  field_t cur_f [NUM_FIELDS];
  field_t alm_f [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] field_hit;
  logic all_hit;

  always_comb begin
    cur_f[0] = time_sec;  alm_f[0] = alm_sec;
    cur_f[1] = time_min;  alm_f[1] = alm_min;
    cur_f[2] = time_hr;   alm_f[2] = alm_hr;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    rtc_alarm_field_cmp u_cmp (
      .cur_val (cur_f[g]),
      .alm_val (alm_f[g]),
      .hit     (field_hit[g])
    );
  end

  assign all_hit = &field_hit;

  rtc_alarm_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_req (upd_done && all_hit),
    .clr_req (flag_clr),
    .flag_q  (alarm_flag)
  );

  assign alarm_irq = alarm_flag & alarm_en;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
  input logic       clk,
  input logic       rst,
  input logic       upd_done,
  input logic [7:0] time_hr,
  input logic [7:0] time_min,
  input logic [7:0] time_sec,
  input logic [7:0] alm_hr,
  input logic [7:0] alm_min,
  input logic [7:0] alm_sec,
  input logic       alarm_en,
  input logic       flag_clr,
  input logic       alarm_flag,
  input logic       alarm_irq
);
  logic want;
  always_comb begin
    want = ((alm_hr[7:6]  == 2'b11) || (alm_hr  == time_hr))  &&
           ((alm_min[7:6] == 2'b11) || (alm_min == time_min)) &&
           ((alm_sec[7:6] == 2'b11) || (alm_sec == time_sec));
  end

  // R2
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_done && want) |=> alarm_flag);

  // R3
  no_update_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_done && !alarm_flag) |=> !alarm_flag);

  // R5
  miss_keeps_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_done && !want && !alarm_flag) |=> !alarm_flag);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !flag_clr) |=> alarm_flag);

  // R6
  clear_works_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !(upd_done && want)) |=> !alarm_flag);

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && upd_done && want) |=> alarm_flag);

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (!alarm_en || !alarm_flag) |-> !alarm_irq);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (.*);

// File: tb/rtc_alarm_match_bench.sv
`timescale 1ns/1ps
module rtc_alarm_match_bench;
  logic clk = 1'b0;
  logic rst, upd_done, alarm_en, flag_clr;
  logic [7:0] time_hr, time_min, time_sec, alm_hr, alm_min, alm_sec;
  logic alarm_flag, alarm_irq;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  rtc_alarm_match u_rtc_alarm_match (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] h, m, s);
    time_hr = h; time_min = m; time_sec = s;
  endtask

  task automatic set_alarm(input logic [7:0] h, m, s);
    alm_hr = h; alm_min = m; alm_sec = s;
  endtask

  // one update strobe; returns at the following negedge
  task automatic do_update(input logic clr);
    @(negedge clk); upd_done = 1'b1; flag_clr = clr;
    @(negedge clk); upd_done = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 flag after reset", alarm_flag, 1'b0);
    check("R1 irq after reset", alarm_irq, 1'b0);
  endtask

  task automatic t_exact();
    alarm_en = 1'b1;
    set_alarm(8'h12, 8'h30, 8'h45);
    set_time(8'h12, 8'h30, 8'h45);
    do_update(1'b0);
    check("R2 exact match sets flag", alarm_flag, 1'b1);
    check("R8 irq follows flag", alarm_irq, 1'b1);
    do_clear();
    check("R6 clear strobe", alarm_flag, 1'b0);
  endtask

  task automatic t_no_strobe();
    set_alarm(8'h05, 8'h06, 8'h07);
    set_time(8'h05, 8'h06, 8'h07);
    repeat (4) @(negedge clk);
    check("R3 match without update", alarm_flag, 1'b0);
  endtask

  task automatic t_mismatch();
    set_alarm(8'h05, 8'h06, 8'h07);
    set_time(8'h04, 8'h06, 8'h07); do_update(1'b0);
    check("R5 hour differs", alarm_flag, 1'b0);
    set_time(8'h05, 8'h16, 8'h07); do_update(1'b0);
    check("R5 minute differs", alarm_flag, 1'b0);
    set_time(8'h05, 8'h06, 8'h08); do_update(1'b0);
    check("R5 second differs", alarm_flag, 1'b0);
    set_alarm(8'hBF, 8'h06, 8'h07);
    set_time(8'h3F, 8'h06, 8'h07); do_update(1'b0);
    check("R4 0xBF is not wildcard", alarm_flag, 1'b0);
    set_alarm(8'h80, 8'h06, 8'h07);
    set_time(8'h00, 8'h06, 8'h07); do_update(1'b0);
    check("R4 0x80 is not wildcard", alarm_flag, 1'b0);
  endtask

  task automatic t_wild();
    set_alarm(8'hC0, 8'h15, 8'h00);
    for (int h = 0; h < 24; h += 7) begin
      set_time(8'(h), 8'h15, 8'h00); do_update(1'b0);
      check("R4 hour wildcard matches", alarm_flag, 1'b1);
      do_clear();
    end
    set_time(8'h09, 8'h16, 8'h00); do_update(1'b0);
    check("R4 hour wildcard still needs minute", alarm_flag, 1'b0);
    set_alarm(8'hFF, 8'hE3, 8'h30);
    set_time(8'h21, 8'h47, 8'h30); do_update(1'b0);
    check("R4 hour+minute wildcard", alarm_flag, 1'b1);
    do_clear();
    set_alarm(8'hC5, 8'hD9, 8'hFF);
    set_time(8'h13, 8'h59, 8'h01); do_update(1'b0);
    check("R4 all wildcards", alarm_flag, 1'b1);
    do_clear();
  endtask

  task automatic t_sticky();
    set_alarm(8'h01, 8'h02, 8'h03);
    set_time(8'h01, 8'h02, 8'h03); do_update(1'b0);
    set_time(8'h01, 8'h02, 8'h04); do_update(1'b0);
    repeat (5) @(negedge clk);
    check("R6 flag holds", alarm_flag, 1'b1);
    set_time(8'h01, 8'h02, 8'h03); do_update(1'b1);
    check("R7 set wins over clear", alarm_flag, 1'b1);
    set_time(8'h01, 8'h02, 8'h05); do_update(1'b1);
    check("R6 clear with missed update", alarm_flag, 1'b0);
  endtask

  task automatic t_enable();
    alarm_en = 1'b0;
    set_alarm(8'h07, 8'h00, 8'h00);
    set_time(8'h07, 8'h00, 8'h00); do_update(1'b0);
    check("R8 flag set while disabled", alarm_flag, 1'b1);
    check("R8 irq off while disabled", alarm_irq, 1'b0);
    alarm_en = 1'b1; #0.5;
    check("R8 irq immediate on enable", alarm_irq, 1'b1);
    @(negedge clk); alarm_en = 1'b0; #0.5;
    check("R8 irq drops with enable", alarm_irq, 1'b0);
    check("R8 flag unaffected by enable", alarm_flag, 1'b1);
    t_reset();
    check("R1 reset clears pending flag", alarm_flag, 1'b0);
  endtask

  initial begin
    rst = 1'b1; upd_done = 1'b0; alarm_en = 1'b0; flag_clr = 1'b0;
    set_time(8'h00, 8'h00, 8'h00); set_alarm(8'h00, 8'h00, 8'h01);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_exact();
    t_no_strobe();
    t_mismatch();
    t_wild();
    t_sticky();
    t_enable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++; n_run++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule